// File: doc/BRIEF.md
# Multi-Source Trigger Router

This block chooses one of five trigger origins and turns the chosen one into a single clean internal trigger pulse. The origins are a software strobe, a single-ended star line, a differential star line (already resolved to a logic level), one of eight shared backplane lines, and a strobe from the analog comparison logic. Every asynchronous line passes through a synchronizer. A software bit selects the active edge. A programmable cycle count rejects glitches that are too short.

An arm strobe gates the output, and each arm lets through exactly one trigger. In master mode the block drives its own trigger onto one chosen backplane line and enables that line's driver only. In slave mode it never drives the backplane and may listen to any one line. All configuration comes in as plain input ports, held steady by the surrounding logic.

Top module: `trig_router`

## Requirements
- R1: After reset `trig_out` is low and the block is disarmed, so a selected software strobe before any `arm` pulse gives no output pulse.
- R2: `src_sel` picks the origin: 0 software, 1 star line, 2 differential star line, 3 backplane line `bp_sel`, 4 analog strobe, and 5 to 7 none. Activity on any origin that is not selected gives no pulse.
- R3: An accepted external edge gives `trig_out` high on the (W+2)th rising clock edge after the input first takes its active level, where W = `min_cycles`, or 1 when `min_cycles` is 0.
- R4: With `pol_fall` = 0 a low-to-high change of the external line is the active edge. With `pol_fall` = 1 a high-to-low change is the active edge.
- R5: An external active level held for fewer than W sampling clock edges gives no pulse. A level held for W or more gives exactly one pulse.
- R6: When software (0) or analog (4) is selected and the block is armed, a high `sw_trig` or `ana_trig` during a cycle gives `trig_out` high on the next clock edge, with no width check.
- R7: After a pulse, further events are ignored until `arm` is pulsed again.
- R8: Each accepted event gives a pulse exactly one cycle wide, even when the event level stays asserted.
- R9: In master mode `bp_oe` is one-hot on bit `bp_sel`. In slave mode `bp_oe` is all zero. `bp_out` carries `trig_out` only on the enabled line.
- R10: In master mode the backplane origin (3) is inert and gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_sel | input | 3 | Trigger origin select (see R2) |
| pol_fall | input | 1 | 1 selects the falling edge of the external line |
| min_cycles | input | CNT_W | Minimum accepted width in clock cycles (0 acts as 1) |
| master_en | input | 1 | 1 = master, drive the backplane line; 0 = slave |
| bp_sel | input | SEL_W | Backplane line index for listening or driving |
| arm | input | 1 | Strobe that allows one trigger |
| sw_trig | input | 1 | Synchronous software trigger strobe |
| ana_trig | input | 1 | Synchronous analog-derived trigger strobe |
| star_in | input | 1 | Asynchronous star trigger line |
| dstar_in | input | 1 | Asynchronous differential star line, as a logic level |
| bp_in | input | N_LINES | Asynchronous backplane trigger lines |
| trig_out | output | 1 | One-cycle internal trigger pulse |
| bp_oe | output | N_LINES | Per-line backplane driver enable |
| bp_out | output | N_LINES | Per-line backplane drive value |

## Verification
External edges are driven with held lengths just below, at and above the programmed width, under both polarities. This separates rejection from acceptance and pins the exact acceptance cycle. Stimulus is also placed on a line or origin other than the selected one, and on the listened backplane line while in master mode, which separates correct routing from a mux that leaks. Software and analog strobes are held for several cycles, with and without a fresh arm, to tell a one-shot from a level follower and an armed block from a disarmed one. Master mode is checked across line indices by comparing the enable and drive vectors during and outside a pulse.

// File: rtl/trig_router_pkg.sv
package trig_router_pkg;

  typedef enum logic [2:0] {
    SRC_SOFT  = 3'd0,
    SRC_STAR  = 3'd1,
    SRC_DSTAR = 3'd2,
    SRC_BPL   = 3'd3,
    SRC_ANA   = 3'd4
  } trig_src_e;

  // Effective width: zero is treated as one cycle
  function automatic logic [31:0] eff_width(input logic [31:0] m);
    return (m == 32'd0) ? 32'd1 : m;
  endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int WIDTH  = 10,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/trig_width_qual.sv
module trig_width_qual
  import trig_router_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             lvl,
  input  logic             pol_fall,
  input  logic [CNT_W-1:0] min_cycles,
  output logic             hit
);
  localparam int CW1 = CNT_W + 1;

  logic             act;      // qualified level, active high
  logic             act_d;
  logic             run;      // counting a level that began with an edge
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] eff;
  logic [CW1-1:0]   cnt_nx;

  assign act    = valid & (lvl ^ pol_fall);
  assign eff    = CNT_W'(eff_width(32'(min_cycles)));
  assign run    = act & (~act_d | (cnt != '0));
  assign cnt_nx = {1'b0, cnt} + CW1'(1);
  assign hit    = run & (cnt_nx == {1'b0, eff});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_d <= 1'b0;
      cnt   <= '0;
    end else begin
      act_d <= act;
      if (!act)                    cnt <= '0;
      else if (run && cnt != eff)  cnt <= cnt_nx[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/trig_bp_drive.sv
module trig_bp_drive #(
  parameter int N_LINES = 8,
  parameter int SEL_W   = $clog2(N_LINES)
) (
  input  logic               master_en,
  input  logic [SEL_W-1:0]   bp_sel,
  input  logic               trig,
  output logic [N_LINES-1:0] oe,
  output logic [N_LINES-1:0] dout
);
  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    assign oe[i]   = master_en & (bp_sel == SEL_W'(i));
    assign dout[i] = oe[i] & trig;
  end
endmodule

// File: rtl/trig_router.sv
module trig_router
  import trig_router_pkg::*;
#(
  parameter int N_LINES     = 8,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(N_LINES),
  localparam int SYNC_W     = N_LINES + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         src_sel,
  input  logic               pol_fall,
  input  logic [CNT_W-1:0]   min_cycles,
  input  logic               master_en,
  input  logic [SEL_W-1:0]   bp_sel,
  input  logic               arm,
  input  logic               sw_trig,
  input  logic               ana_trig,
  input  logic               star_in,
  input  logic               dstar_in,
  input  logic [N_LINES-1:0] bp_in,
  output logic               trig_out,
  output logic [N_LINES-1:0] bp_oe,
  output logic [N_LINES-1:0] bp_out
);
  trig_src_e          src;
  logic [SYNC_W-1:0]  raw_lines;
  logic [SYNC_W-1:0]  sync_lines;
  logic               star_s;
  logic               dstar_s;
  logic [N_LINES-1:0] bp_s;
  logic               ext_lvl;
  logic               ext_valid;
  logic               ext_hit;
  logic               sync_evt;
  logic               any_evt;
  logic               armed;

  assign src       = trig_src_e'(src_sel);
  assign raw_lines = {bp_in, dstar_in, star_in};

  trig_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (raw_lines),
    .q (sync_lines)
  );

  assign star_s  = sync_lines[0];
  assign dstar_s = sync_lines[1];
  assign bp_s    = sync_lines[SYNC_W-1:2];

  // External origin multiplexer
  always_comb begin
    ext_lvl   = 1'b0;
    ext_valid = 1'b0;
    case (src)
      SRC_STAR:  begin ext_lvl = star_s;       ext_valid = 1'b1;       end
      SRC_DSTAR: begin ext_lvl = dstar_s;      ext_valid = 1'b1;       end
      SRC_BPL:   begin ext_lvl = bp_s[bp_sel]; ext_valid = ~master_en; end
      default:   begin ext_lvl = 1'b0;         ext_valid = 1'b0;       end
    endcase
  end

  trig_width_qual #(.CNT_W(CNT_W)) u_qual (
    .clk (clk),
    .rst_n (rst_n),
    .valid (ext_valid),
    .lvl (ext_lvl),
    .pol_fall (pol_fall),
    .min_cycles (min_cycles),
    .hit (ext_hit)
  );

  assign sync_evt = ((src == SRC_SOFT) & sw_trig) | ((src == SRC_ANA) & ana_trig);
  assign any_evt  = sync_evt | ext_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      trig_out <= 1'b0;
    end else begin
      trig_out <= armed & any_evt;
      if (arm)                  armed <= 1'b1;
      else if (armed & any_evt) armed <= 1'b0;
    end
  end

  trig_bp_drive #(.N_LINES(N_LINES), .SEL_W(SEL_W)) u_drive (
    .master_en (master_en),
    .bp_sel (bp_sel),
    .trig (trig_out),
    .oe (bp_oe),
    .dout (bp_out)
  );
endmodule

// File: rtl/trig_router_chk.sv
module trig_router_chk #(
  parameter int N_LINES = 8,
  parameter int SEL_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         src_sel,
  input logic               master_en,
  input logic [SEL_W-1:0]   bp_sel,
  input logic               arm,
  input logic               sw_trig,
  input logic               armed,
  input logic               trig_out,
  input logic [N_LINES-1:0] bp_oe,
  input logic [N_LINES-1:0] bp_out
);
  a_r7_disarmed_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !trig_out);

  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out && !$past(arm)) |=> !trig_out);

  a_r6_soft_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && src_sel == 3'd0 && sw_trig) |=> trig_out);

  a_r9_oe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bp_oe));

  a_r9_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> (bp_oe == '0 && bp_out == '0));

  a_r9_sel_line: assert property (@(posedge clk) disable iff (!rst_n)
    master_en |-> bp_oe[bp_sel]);

  a_r9_drive_needs_trig: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_out != '0) |-> trig_out);
endmodule

bind trig_router trig_router_chk #(.N_LINES(N_LINES), .SEL_W(SEL_W)) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .src_sel (src_sel),
  .master_en (master_en),
  .bp_sel (bp_sel),
  .arm (arm),
  .sw_trig (sw_trig),
  .armed (armed),
  .trig_out (trig_out),
  .bp_oe (bp_oe),
  .bp_out (bp_out)
);

// File: tb/trig_router_tb.sv
`timescale 1ns/1ps
module trig_router_tb;
  localparam int NL = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    src_sel;
  logic          pol_fall;
  logic [15:0]   min_cycles;
  logic          master_en;
  logic [2:0]    bp_sel;
  logic          arm, sw_trig, ana_trig, star_in, dstar_in;
  logic [NL-1:0] bp_in;
  logic          trig_out;
  logic [NL-1:0] bp_oe, bp_out;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  trig_router u_dut (
    .clk, .rst_n, .src_sel, .pol_fall, .min_cycles, .master_en, .bp_sel,
    .arm, .sw_trig, .ana_trig, .star_in, .dstar_in, .bp_in,
    .trig_out, .bp_oe, .bp_out
  );

  function automatic int width_of(int m);
    return (m < 1) ? 1 : m;
  endfunction

  function automatic bit fires(int s, int ds, int dl, int bs, bit mst, int mc, int hold);
    if (s < 1 || s > 3 || ds != s) return 1'b0;
    if (s == 3 && (dl != bs || mst)) return 1'b0;
    return hold >= width_of(mc);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic pulse_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic ext_trial(int s, int ds, int dl, int bs, bit pol, int mc,
                           int hold, bit mst, string req);
    int first = 0;
    int cnt = 0;
    bit exp_f;
    @(negedge clk);
    src_sel = 3'(s); bp_sel = 3'(bs); pol_fall = pol; min_cycles = 16'(mc);
    master_en = mst; star_in = pol; dstar_in = pol; bp_in = {NL{pol}};
    repeat (8) @(negedge clk);
    pulse_arm();
    @(negedge clk);
    case (ds)
      1: star_in = ~pol;
      2: dstar_in = ~pol;
      3: bp_in[dl] = ~pol;
      default: ;
    endcase
    for (int i = 1; i <= width_of(mc) + hold + 12; i++) begin
      @(posedge clk); @(negedge clk);
      if (i == hold) begin star_in = pol; dstar_in = pol; bp_in = {NL{pol}}; end
      if (trig_out) begin cnt++; if (first == 0) first = i; end
    end
    exp_f = fires(s, ds, dl, bs, mst, mc, hold);
    chk(cnt == int'(exp_f), req, "pulse count", cnt, int'(exp_f));
    if (exp_f) chk(first == width_of(mc) + 2, "R3", "acceptance cycle", first, width_of(mc) + 2);
  endtask

  // which: 0 software strobe, 1 analog strobe
  task automatic strobe_trial(int s, bit which, bit do_arm, int len, bit exp_f, string req);
    int first = 0;
    int cnt = 0;
    @(negedge clk);
    src_sel = 3'(s);
    if (do_arm) pulse_arm();
    @(negedge clk);
    if (which) ana_trig = 1'b1; else sw_trig = 1'b1;
    for (int i = 1; i <= len + 6; i++) begin
      @(posedge clk); @(negedge clk);
      if (i == len) begin sw_trig = 1'b0; ana_trig = 1'b0; end
      if (trig_out) begin cnt++; if (first == 0) first = i; end
      chk(bp_out == (trig_out ? bp_oe : '0), "R9", "drive vector", int'(bp_out),
          int'(trig_out ? bp_oe : '0));
    end
    chk(cnt == int'(exp_f), req, "strobe pulse count", cnt, int'(exp_f));
    if (exp_f) chk(first == 1, "R6", "strobe latency", first, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; src_sel = 3'd0; pol_fall = 1'b0; min_cycles = 16'd38;
    master_en = 1'b0; bp_sel = 3'd0; arm = 1'b0; sw_trig = 1'b0; ana_trig = 1'b0;
    star_in = 1'b0; dstar_in = 1'b0; bp_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(trig_out == 1'b0, "R1", "trig_out after reset", int'(trig_out), 0);
    chk(bp_oe == '0, "R9", "slave enables", int'(bp_oe), 0);
    strobe_trial(0, 0, 0, 1, 0, "R1");            // disarmed after reset

    // Software and analog strobes
    strobe_trial(0, 0, 1, 3, 1, "R8");            // held strobe: one pulse
    strobe_trial(0, 0, 0, 1, 0, "R7");            // no re-arm: ignored
    strobe_trial(4, 1, 1, 1, 1, "R6");
    strobe_trial(4, 0, 1, 1, 0, "R2");            // sw while analog selected
    strobe_trial(0, 1, 0, 1, 0, "R2");            // armed, analog while sw selected
    strobe_trial(0, 0, 0, 1, 1, "R7");            // still armed from before
    strobe_trial(5, 0, 1, 1, 0, "R2");            // unused code

    // Master mode across line indices
    for (int k = 0; k < NL; k += 3) begin
      @(negedge clk); master_en = 1'b1; bp_sel = 3'(k);
      @(negedge clk);
      chk(bp_oe == NL'(1) << k, "R9", "master enable", int'(bp_oe), 1 << k);
      strobe_trial(0, 0, 1, 2, 1, "R9");
    end
    @(negedge clk); master_en = 1'b0;
    @(negedge clk);
    chk(bp_oe == '0, "R9", "slave enables", int'(bp_oe), 0);

    // Directed width corners, both polarities
    ext_trial(1, 1, 0, 0, 0, 38, 37, 0, "R5");
    ext_trial(1, 1, 0, 0, 0, 38, 38, 0, "R5");
    ext_trial(2, 2, 0, 0, 1, 5, 4, 0, "R4");
    ext_trial(2, 2, 0, 0, 1, 5, 6, 0, "R4");
    ext_trial(3, 3, 6, 6, 0, 0, 1, 0, "R3");
    ext_trial(3, 3, 2, 6, 0, 3, 8, 0, "R2");       // other backplane line
    ext_trial(1, 2, 0, 0, 0, 3, 8, 0, "R2");       // other star line
    ext_trial(3, 3, 4, 4, 0, 3, 8, 1, "R10");      // master ignores backplane

    // Constrained random trials
    for (int t = 0; t < 30; t++) begin
      int s  = 1 + int'($urandom % 3);
      int ds = ($urandom % 4 == 0) ? int'($urandom % 4) : s;
      int bs = int'($urandom % NL);
      int dl = ($urandom % 3 == 0) ? int'($urandom % NL) : bs;
      bit pol = 1'($urandom);
      int mc = int'($urandom % 11);
      int hold = 1 + int'($urandom % (width_of(mc) + 3));
      bit mst = ($urandom % 5 == 0);
      ext_trial(s, ds, dl, bs, pol, mc, hold, mst, "R5");
    end
    summary();
  end
endmodule